// File: doc/BRIEF.md
# Peripheral DMA Channel with Buffer Reload

This block is one peripheral DMA channel. Each time the chosen peripheral request line is high, it moves one data item between that peripheral and a memory buffer. Software sets up the channel through a small register port: a live buffer address, a live item count, a configuration word, and a second address and count held in reserve. The configuration word picks the peripheral line, the item size and the direction.

Each item makes a single memory access. That access stays on the bus until the bus ready input is high. The peripheral is acknowledged only after the access finishes. The address then moves forward by the item size and the count drops by one.

When the live count reaches zero and a reserve count is waiting, the channel copies the reserve pair into the live registers and clears the reserve count. It then carries on in the second buffer with no software action at the boundary. When both counts are zero, the channel stops and raises a sticky completion flag. A level flag shows that the reserve count is empty. Either flag can be enabled onto a single interrupt line.

Top module: `pdma_chan`

## Requirements
- R1: After reset, the following are all zero: the live address, the live count, the reserve count, the completion flag, `irq`, `mem_req` and every `per_ack` line.
- R2: An item starts only when the live count is nonzero and the request line chosen by configuration bits [SEL_W-1:0] (offset 1) is high. Requests on the other lines have no effect.
- R3: `mem_req` stays high with a stable `mem_addr` until `mem_ready` is seen. One cycle later, only the chosen `per_ack` line pulses for one cycle.
- R4: After each item, the live address grows by 1, 2 or 4 for size field values 0, 1 or 2 (configuration bits [9:8]). The value 3 steps by 4.
- R5: The live count (offset 2) drops by one per finished item. The live address (offset 0) and the live count can be read at any time.
- R6: When the channel is idle, the live count is zero and the reserve count (offset 4) is nonzero, the live address and count load from the reserve address (offset 3) and the reserve count. The reserve count then clears to zero.
- R7: With both counts zero, requests are not served. The completion flag (status bit 0, offset 5) sets when the last item finishes with no reserve pending. It stays set until software writes 1 to status bit 0.
- R8: Status bit 1 reads 1 exactly while the reserve count is zero.
- R9: `irq` is high when (completion AND enable bit 0) OR (reserve-empty AND enable bit 1). The enable bits are at offset 6.
- R10: Configuration bit 16 sets the direction. With 0, the chosen peripheral's data is written to memory (`mem_we`=1). With 1, memory is read (`mem_we`=0) and the read data appears on `per_data_o` during the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_ofs | input | 3 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_ofs` |
| per_req | input | NUM_PERIPH | Peripheral request lines |
| per_ack | output | NUM_PERIPH | Peripheral acknowledge lines |
| per_data_i | input | NUM_PERIPH*DATA_W | Data from each peripheral |
| per_data_o | output | DATA_W | Data to the peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory access finished |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the channel with its defaults: four peripheral lines, 32-bit data and addresses, and a 16-bit count. Four lines are enough to show that a request on a line that is not selected is ignored, and that the acknowledge reaches only the chosen line. The 32-bit address lets the test run a full three-plus-two item sequence across a reload boundary. It also covers all three step sizes, waiting bus cycles, both directions and the stopped state.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_ACK  = 2'd2
  } xfer_st_e;

  localparam logic [2:0] OFS_ADDR  = 3'd0;
  localparam logic [2:0] OFS_CFG   = 3'd1;
  localparam logic [2:0] OFS_CNT   = 3'd2;
  localparam logic [2:0] OFS_RADDR = 3'd3;
  localparam logic [2:0] OFS_RCNT  = 3'd4;
  localparam logic [2:0] OFS_STAT  = 3'd5;
  localparam logic [2:0] OFS_IEN   = 3'd6;

  localparam int CFG_SIZE_LSB = 8;
  localparam int CFG_DIR_BIT  = 16;

  // byte step for one item of the given size code
  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (sz)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        ofs,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              item_done,
  input  logic              xfer_idle,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rcnt,
  output logic [SEL_W-1:0]  sel,
  output logic [1:0]        size,
  output logic              dir,
  output logic              irq
);

  logic [ADDR_W-1:0] addr_q, addr_nx, raddr_q, raddr_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, rcnt_q, rcnt_nx;
  logic [SEL_W-1:0]  sel_q, sel_nx;
  logic [1:0]        size_q, size_nx;
  logic              dir_q, dir_nx;
  logic              done_q, done_nx;
  logic [1:0]        ien_q, ien_nx;
  logic              reload, last_item, rempty;
  logic              w_addr, w_cfg, w_cnt, w_raddr, w_rcnt, w_stat, w_ien;

  assign w_addr  = wr_en && (ofs == OFS_ADDR);
  assign w_cfg   = wr_en && (ofs == OFS_CFG);
  assign w_cnt   = wr_en && (ofs == OFS_CNT);
  assign w_raddr = wr_en && (ofs == OFS_RADDR);
  assign w_rcnt  = wr_en && (ofs == OFS_RCNT);
  assign w_stat  = wr_en && (ofs == OFS_STAT);
  assign w_ien   = wr_en && (ofs == OFS_IEN);

  assign rempty    = (rcnt_q == '0);
  assign reload    = xfer_idle && (cnt_q == '0) && !rempty;
  assign last_item = item_done && (cnt_q == CNT_W'(1)) && rempty;

  // next-state: hardware progress first, software writes take priority
  always_comb begin
    addr_nx  = addr_q;
    cnt_nx   = cnt_q;
    raddr_nx = raddr_q;
    rcnt_nx  = rcnt_q;
    sel_nx   = sel_q;
    size_nx  = size_q;
    dir_nx   = dir_q;
    ien_nx   = ien_q;

    if (item_done) begin
      addr_nx = addr_q + ADDR_W'(step_of(size_q));
      cnt_nx  = cnt_q - CNT_W'(1);
    end else if (reload) begin
      addr_nx = raddr_q;
      cnt_nx  = rcnt_q;
      rcnt_nx = '0;
    end

    if (w_addr)  addr_nx  = wdata[ADDR_W-1:0];
    if (w_cnt)   cnt_nx   = wdata[CNT_W-1:0];
    if (w_raddr) raddr_nx = wdata[ADDR_W-1:0];
    if (w_rcnt)  rcnt_nx  = wdata[CNT_W-1:0];
    if (w_cfg) begin
      sel_nx  = wdata[SEL_W-1:0];
      size_nx = wdata[CFG_SIZE_LSB +: 2];
      dir_nx  = wdata[CFG_DIR_BIT];
    end
    if (w_ien)   ien_nx   = wdata[1:0];

    done_nx = (done_q && !(w_stat && wdata[0])) || last_item;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      raddr_q <= '0;
      rcnt_q  <= '0;
      sel_q   <= '0;
      size_q  <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      ien_q   <= '0;
    end else begin
      addr_q  <= addr_nx;
      cnt_q   <= cnt_nx;
      raddr_q <= raddr_nx;
      rcnt_q  <= rcnt_nx;
      sel_q   <= sel_nx;
      size_q  <= size_nx;
      dir_q   <= dir_nx;
      done_q  <= done_nx;
      ien_q   <= ien_nx;
    end
  end

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_ADDR:  rdata[ADDR_W-1:0] = addr_q;
      OFS_CFG: begin
        rdata[SEL_W-1:0]            = sel_q;
        rdata[CFG_SIZE_LSB +: 2]    = size_q;
        rdata[CFG_DIR_BIT]          = dir_q;
      end
      OFS_CNT:   rdata[CNT_W-1:0]  = cnt_q;
      OFS_RADDR: rdata[ADDR_W-1:0] = raddr_q;
      OFS_RCNT:  rdata[CNT_W-1:0]  = rcnt_q;
      OFS_STAT:  rdata[1:0]        = {rempty, done_q};
      OFS_IEN:   rdata[1:0]        = ien_q;
      default:   rdata = '0;
    endcase
  end

  assign addr = addr_q;
  assign cnt  = cnt_q;
  assign rcnt = rcnt_q;
  assign sel  = sel_q;
  assign size = size_q;
  assign dir  = dir_q;
  assign irq  = (done_q && ien_q[0]) || (rempty && ien_q[1]);

endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SEL_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           sel,
  input  logic                       dir,
  input  logic [1:0]                 size,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [NUM_PERIPH-1:0]      per_req,
  output logic [NUM_PERIPH-1:0]      per_ack,
  input  logic [NUM_PERIPH*DATA_W-1:0] per_data_i,
  output logic [DATA_W-1:0]          per_data_o,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [1:0]                 mem_size,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic                       mem_ready,
  output logic                       item_done,
  output logic                       idle
);

  xfer_st_e st_q, st_nx;
  logic [SEL_W-1:0]      sel_lat_q, sel_lat_nx;
  logic                  dir_lat_q, dir_lat_nx;
  logic [DATA_W-1:0]     buf_q, buf_nx;
  logic                  buf_en;
  logic [NUM_PERIPH-1:0] sel_oh;
  logic [DATA_W-1:0]     lane [NUM_PERIPH];
  logic [DATA_W-1:0]     sel_data;
  logic                  req_sel, start;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_lane
    assign lane[g]    = per_data_i[g*DATA_W +: DATA_W];
    assign sel_oh[g]  = (sel == SEL_W'(g));
    assign per_ack[g] = (st_q == ST_ACK) && (sel_lat_q == SEL_W'(g));
  end

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (sel_oh[i]) sel_data = lane[i];
    end
  end

  assign req_sel = |(per_req & sel_oh);
  assign start   = (st_q == ST_IDLE) && (cnt != '0) && req_sel;

  always_comb begin
    st_nx      = st_q;
    sel_lat_nx = sel_lat_q;
    dir_lat_nx = dir_lat_q;
    buf_nx     = buf_q;
    buf_en     = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_nx      = ST_BUS;
        sel_lat_nx = sel;
        dir_lat_nx = dir;
        if (!dir) begin
          buf_nx = sel_data;
          buf_en = 1'b1;
        end
      end
      ST_BUS: if (mem_ready) begin
        st_nx = ST_ACK;
        if (dir_lat_q) begin
          buf_nx = mem_rdata;
          buf_en = 1'b1;
        end
      end
      ST_ACK:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sel_lat_q <= '0;
      dir_lat_q <= 1'b0;
      buf_q     <= '0;
    end else begin
      st_q <= st_nx;
      if (start) begin
        sel_lat_q <= sel_lat_nx;
        dir_lat_q <= dir_lat_nx;
      end
      if (buf_en) buf_q <= buf_nx;
    end
  end

  assign mem_req    = (st_q == ST_BUS);
  assign mem_we     = !dir_lat_q;
  assign mem_addr   = addr;
  assign mem_size   = size;
  assign mem_wdata  = buf_q;
  assign per_data_o = buf_q;
  assign item_done  = (st_q == ST_ACK);
  assign idle       = (st_q == ST_IDLE);

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr_en,
  input  logic [2:0]                   cfg_ofs,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  input  logic [NUM_PERIPH-1:0]        per_req,
  output logic [NUM_PERIPH-1:0]        per_ack,
  input  logic [NUM_PERIPH*DATA_W-1:0] per_data_i,
  output logic [DATA_W-1:0]            per_data_o,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [1:0]                   mem_size,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         mem_ready,
  output logic                         irq
);

  localparam int SEL_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt, cur_rcnt;
  logic [SEL_W-1:0]  cur_sel;
  logic [1:0]        cur_size;
  logic              cur_dir, item_done, xfer_idle;

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .ofs(cfg_ofs), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .item_done(item_done), .xfer_idle(xfer_idle),
    .addr(cur_addr), .cnt(cur_cnt), .rcnt(cur_rcnt),
    .sel(cur_sel), .size(cur_size), .dir(cur_dir), .irq(irq)
  );

  pdma_xfer #(.NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
              .DATA_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .sel(cur_sel), .dir(cur_dir), .size(cur_size), .addr(cur_addr), .cnt(cur_cnt),
    .per_req(per_req), .per_ack(per_ack), .per_data_i(per_data_i), .per_data_o(per_data_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .item_done(item_done), .idle(xfer_idle)
  );

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int NUM_PERIPH = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_wr_en,
  input logic                  mem_req,
  input logic                  mem_ready,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [NUM_PERIPH-1:0] per_ack,
  input logic [CNT_W-1:0]      cur_cnt,
  input logic [CNT_W-1:0]      cur_rcnt
);

  // R3: bus request held with stable address while not ready
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !cfg_wr_en) |=> (mem_req && $stable(mem_addr)));

  // R3: acknowledge only right after a finished memory beat
  a_r3_ack_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack != '0) |-> $past(mem_req && mem_ready));

  // R3: at most one acknowledge line
  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack));

  // R5: count drops by one per finished item
  a_r5_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_ack != '0) && !cfg_wr_en) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  // R6: idle with empty live count and pending reserve reloads
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_cnt == '0) && (cur_rcnt != '0) && !mem_req && (per_ack == '0) && !cfg_wr_en)
      |=> ((cur_cnt == $past(cur_rcnt)) && (cur_rcnt == '0)));

  // R7: stopped channel issues no bus request
  a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_cnt == '0) && (cur_rcnt == '0) && !mem_req && !cfg_wr_en) |=> !mem_req);

endmodule

bind pdma_chan pdma_chan_chk #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .mem_req(mem_req),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .per_ack(per_ack),
  .cur_cnt(cur_cnt), .cur_rcnt(cur_rcnt)
);

// File: tb/pdma_chan_test.sv
module pdma_chan_test;

  localparam int NP = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [2:0]        cfg_ofs = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [NP-1:0]     per_req = '0;
  logic [NP-1:0]     per_ack;
  logic [NP*DW-1:0]  per_data_i = '0;
  logic [DW-1:0]     per_data_o;
  logic              mem_req, mem_we;
  logic [AW-1:0]     mem_addr;
  logic [1:0]        mem_size;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     mem_rdata = '0;
  logic              mem_ready = 1'b0;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pdma_chan #(.NUM_PERIPH(NP), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_ofs(cfg_ofs),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req), .per_ack(per_ack),
    .per_data_i(per_data_i), .per_data_o(per_data_o), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq(irq)
  );

  // {peripheral data, expected address, bus wait cycles, expected count after}
  localparam logic [87:0] VEC [5] = '{
    {32'h0000_00A1, 32'h0000_0100, 8'd0, 16'd2},
    {32'h0000_00B2, 32'h0000_0104, 8'd3, 16'd1},
    {32'h0000_00C3, 32'h0000_0108, 8'd1, 16'd2},
    {32'h0000_00D4, 32'h0000_0200, 8'd0, 16'd1},
    {32'h0000_00E5, 32'h0000_0204, 8'd2, 16'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_ofs = o; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, output logic [31:0] d);
    @(negedge clk);
    cfg_ofs = o;
    #1 d = cfg_rdata;
  endtask

  // one item on line ln; returns what the bus and peripheral saw
  task automatic item(input int ln, input logic [31:0] pd, input int waitc,
                      input logic [31:0] rdat,
                      output logic [31:0] a, output logic [31:0] wd, output logic we,
                      output logic [NP-1:0] ack, output logic [31:0] pdo);
    int t;
    @(negedge clk);
    per_data_i[ln*DW +: DW] = pd;
    per_req[ln] = 1'b1;
    t = 0;
    while (!mem_req && t < 50) begin @(negedge clk); t++; end
    a = mem_addr; wd = mem_wdata; we = mem_we;
    repeat (waitc) @(negedge clk);
    mem_rdata = rdat; mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    ack = per_ack; pdo = per_data_o;
    per_req[ln] = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r, a, wd, pdo;
    logic we;
    logic [NP-1:0] ack;
    int hits;

    // R1: reset state
    repeat (3) @(negedge clk);
    rd(3'd0, r); chk("R1 addr", r, 32'h0);
    rd(3'd2, r); chk("R1 count", r, 32'h0);
    rd(3'd4, r); chk("R1 reserve count", r, 32'h0);
    rd(3'd5, r); chk("R1 status", r, 32'h2);
    chk("R1 irq/mem_req/ack", {irq, mem_req, per_ack}, 32'h0);
    rst_n = 1'b1;

    // setup: line 1, 4-byte items, peripheral to memory
    wr(3'd1, 32'h0000_0201);
    wr(3'd0, 32'h100);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h200);
    wr(3'd4, 32'd2);

    for (int i = 0; i < 5; i++) begin
      item(1, VEC[i][87:56], int'(VEC[i][23:16]), 32'h0, a, wd, we, ack, pdo);
      chk("R4 mem_addr", a, VEC[i][55:24]);
      chk("R10 write data", wd, VEC[i][87:56]);
      chk("R10 write dir", {31'b0, we}, 32'h1);
      chk("R3 ack line", {28'b0, ack}, 32'h2);
      @(negedge clk);
      rd(3'd2, r); chk("R5 R6 count", r, {16'b0, VEC[i][15:0]});
      if (i == 2) begin
        rd(3'd0, r); chk("R6 reload addr", r, 32'h200);
        rd(3'd4, r); chk("R6 reserve cleared", r, 32'h0);
      end
    end

    // R7/R8/R9 flags
    rd(3'd5, r); chk("R7 R8 status", r, 32'h3);
    chk("R9 irq disabled", {31'b0, irq}, 32'h0);
    wr(3'd6, 32'h1);
    #1 chk("R9 irq done", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, r); chk("R7 done cleared", r, 32'h2);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);

    // R7: stopped channel ignores requests
    hits = 0;
    @(negedge clk); per_req[1] = 1'b1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (mem_req) hits++; end
    per_req[1] = 1'b0;
    chk("R7 no request when stopped", hits, 0);

    // R2: unselected line ignored; R4 2-byte step
    wr(3'd0, 32'h300);
    wr(3'd1, 32'h0000_0101);
    wr(3'd2, 32'd1);
    hits = 0;
    @(negedge clk); per_req[2] = 1'b1;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (mem_req || per_ack != 0) hits++; end
    per_req[2] = 1'b0;
    chk("R2 other line ignored", hits, 0);
    rd(3'd2, r); chk("R2 count kept", r, 32'd1);
    item(1, 32'h77, 0, 32'h0, a, wd, we, ack, pdo);
    chk("R2 selected served", a, 32'h300);
    @(negedge clk);
    rd(3'd0, r); chk("R4 step 2", r, 32'h302);

    // R10 read direction, R4 1-byte step, line 3
    wr(3'd1, 32'h0001_0003);
    wr(3'd0, 32'h400);
    wr(3'd2, 32'd2);
    item(3, 32'h0, 1, 32'h5A, a, wd, we, ack, pdo);
    chk("R10 read dir", {31'b0, we}, 32'h0);
    chk("R10 per_data_o", pdo, 32'h5A);
    chk("R3 ack line 3", {28'b0, ack}, 32'h8);
    item(3, 32'h0, 0, 32'h6B, a, wd, we, ack, pdo);
    chk("R4 step 1", a, 32'h401);

    // R8 reserve nonempty, R9 enable bit 1
    wr(3'd2, 32'd7);
    wr(3'd4, 32'd5);
    rd(3'd5, r); chk("R8 reserve pending", {30'b0, r[1:0]} & 32'h2, 32'h0);
    wr(3'd6, 32'h2);
    #1 chk("R9 irq reserve-empty off", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'd0);
    #1 chk("R9 irq reserve-empty on", {31'b0, irq}, 32'h1);

    finish_run();
  end

endmodule